// File: doc/BRIEF.md
# DSD-over-PCM Unpacker with DSD Serial Output

This block sits behind an audio streaming engine that delivers stereo samples in PCM frames. Some of those streams are not PCM at all: they carry one-bit DSD audio, either wrapped in 24-bit words whose top byte is a marker and whose low 16 bits are DSD bits, or packed as plain 32-bit words of DSD bits when the direct carriage mode is selected. The block watches the marker bytes. Once a steady alternating marker pattern is seen, it switches into DSD mode and unpacks the bits onto a left and a right serial line with a bit clock.

Two status outputs report the mode. The DSD mode flag also serves as the active-low reset of an external DSD converter. The rate flag tells the converter whether the double-rate variant is playing. The bit clock is divided from the system clock. The high rate class gives the doubled bit rate. Direct carriage always runs at the base rate. Data changes only while the bit clock is low, so the converter can sample on the rising edge. When no word is ready, the lines carry the DSD silence pattern.

Top module: `dsd_unpack`

## Requirements
- R1: While and after reset, dsd_clk, dsd_dl, dsd_dr, dsd_flag and dsd_128 are all 0.
- R2: With direct_sel low, a frame fits when bits [23:16] of both channels are equal, are 0x05 or 0xFA, and differ from the previous fitting frame's marker. dsd_flag rises at the clock edge that takes the fourth consecutive fitting frame. Three fitting frames are not enough.
- R3: A frame whose channels disagree, or whose marker is neither 0x05 nor 0xFA, sets the fitting-run count to 0. A valid marker that repeats the previous one starts a new run of length 1.
- R4: In DSD-over-PCM mode a single non-fitting frame is tolerated. dsd_flag falls at the edge that takes the second consecutive non-fitting frame.
- R5: dsd_128 is 1 exactly while DSD-over-PCM mode is active and rate_hi is 1. It is updated at the same edges as dsd_flag, and it is 0 in direct mode.
- R6: With CLK_HALF = 2, the dsd_clk period is 4*CLK_HALF system cycles (8) at the base rate and 2*CLK_HALF (4) at the double rate.
- R7: dsd_dl and dsd_dr change only while dsd_clk is low, and they stay stable while it is high. With dsd_flag low, dsd_clk, dsd_dl and dsd_dr are 0.
- R8: The low 16 bits of each fitting frame taken while the mode is (or becomes) DSD are sent MSB first, one bit per rising edge of dsd_clk, in arrival order. The first bit of the frame that completes acquisition is already present at the first rising edge.
- R9: direct_sel = 1 raises dsd_flag at the next edge with dsd_128 = 0. Each valid 32-bit word is sent MSB first at the base rate. Clearing direct_sel drops dsd_flag at the next edge.
- R10: When a word finishes and none is pending, each line sends the byte 0x69 MSB first (0,1,1,0,1,0,0,1), one byte at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A stereo frame is present this cycle |
| smp_left | input | WORD_W | Left-channel word |
| smp_right | input | WORD_W | Right-channel word |
| rate_hi | input | 1 | Frame rate class is the high (double DSD rate) one |
| direct_sel | input | 1 | Frames carry direct 32-bit DSD words |
| dsd_clk | output | 1 | DSD bit clock |
| dsd_dl | output | 1 | Left DSD bit line |
| dsd_dr | output | 1 | Right DSD bit line |
| dsd_flag | output | 1 | 1 in DSD mode, 0 in PCM mode (converter reset when 0) |
| dsd_128 | output | 1 | 1 for the double DSD rate |

## Verification
dsd_flag and dsd_128 are registered, so they reflect a frame one system edge after the frame is taken. The bench drives each frame on a falling clock edge and reads the flags at the next falling edge. Serial bits are loaded one edge after the load is decided and hold through the high phase. The bench therefore records a bit at the first falling system edge after each rise of dsd_clk and measures the rise-to-rise distance there. Payload and silence checks compare whole captured words only after enough bit periods have passed for the word to drain: 16 or 32 bits times 4*CLK_HALF cycles.

// File: rtl/dsd_unpack_pkg.sv
package dsd_unpack_pkg;

  localparam logic [7:0] DOP_MARK_LO = 8'h05;
  localparam logic [7:0] DOP_MARK_HI = 8'hFA;
  localparam logic [7:0] DSD_SILENCE = 8'h69;
  localparam int         DOP_BITS    = 16;
  localparam int         MARK_LSB    = 16;

  typedef struct packed {
    logic marker_ok;  // both channels carry the same legal marker
    logic in_step;    // marker also alternates with the previous frame
  } verdict_t;

  function automatic logic is_marker(input logic [7:0] m);
    return (m == DOP_MARK_LO) || (m == DOP_MARK_HI);
  endfunction

  function automatic verdict_t judge(input logic [7:0] ml, input logic [7:0] mr,
                                     input logic last_ok, input logic [7:0] last_mark);
    verdict_t v;
    v.marker_ok = (ml == mr) && is_marker(ml);
    v.in_step   = v.marker_ok && (!last_ok || (ml != last_mark));
    return v;
  endfunction

endpackage

// File: rtl/dsd_marker_detect.sv
module dsd_marker_detect
  import dsd_unpack_pkg::*;
#(
  parameter int ACQ_FRAMES  = 4,
  parameter int LOSS_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_valid,
  input  logic [7:0] mark_l,
  input  logic [7:0] mark_r,
  input  logic       direct_sel,
  input  logic       rate_hi,
  output logic       dsd_on,
  output logic       dsd_hi,
  output logic       acq_evt,
  output logic       loss_evt,
  output logic       push
);

  localparam int RUN_W = $clog2(ACQ_FRAMES + 1);
  localparam int BAD_W = $clog2(LOSS_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(ACQ_FRAMES);
  localparam logic [BAD_W-1:0] BAD_FULL = BAD_W'(LOSS_FRAMES);

  logic [RUN_W-1:0] run_q, run_nxt;
  logic [BAD_W-1:0] bad_q, bad_nxt;
  logic             last_ok_q;
  logic [7:0]       last_mark_q;
  logic             dop_q, dop_nxt, direct_q, hi_q;
  logic             dop_frame;
  verdict_t         v;

  assign dop_frame = frm_valid && !direct_sel;

  always_comb begin
    v = judge(mark_l, mark_r, last_ok_q, last_mark_q);
    if (v.in_step)        run_nxt = (run_q == RUN_FULL) ? run_q : run_q + 1'b1;
    else if (v.marker_ok) run_nxt = RUN_W'(1);
    else                  run_nxt = '0;
    if (v.in_step) bad_nxt = '0;
    else           bad_nxt = (bad_q == BAD_FULL) ? bad_q : bad_q + 1'b1;
    dop_nxt = dop_q;
    if (direct_sel)     dop_nxt = 1'b0;
    else if (frm_valid) dop_nxt = dop_q ? (bad_nxt != BAD_FULL) : (run_nxt == RUN_FULL);
  end

  assign acq_evt  = dop_frame && !dop_q && dop_nxt;
  assign loss_evt = dop_frame && dop_q && !dop_nxt;
  assign push     = frm_valid && (direct_sel || (dop_nxt && v.in_step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      bad_q       <= '0;
      last_ok_q   <= 1'b0;
      last_mark_q <= '0;
      dop_q       <= 1'b0;
      direct_q    <= 1'b0;
      hi_q        <= 1'b0;
    end else begin
      dop_q    <= dop_nxt;
      direct_q <= direct_sel;
      hi_q     <= !direct_sel && rate_hi && dop_nxt;
      if (direct_sel) begin
        run_q     <= '0;
        bad_q     <= '0;
        last_ok_q <= 1'b0;
      end else if (frm_valid) begin
        run_q       <= run_nxt;
        bad_q       <= bad_nxt;
        last_ok_q   <= v.marker_ok;
        last_mark_q <= mark_l;
      end
    end
  end

  assign dsd_on = dop_q | direct_q;
  assign dsd_hi = hi_q;

endmodule

// File: rtl/dsd_clkgen.sv
module dsd_clkgen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fast,
  output logic clk_out,
  output logic tick
);

  localparam int DIV_W = (2 * CLK_HALF > 1) ? $clog2(2 * CLK_HALF) : 1;
  localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'(CLK_HALF - 1);
  localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(2 * CLK_HALF - 1);

  logic [DIV_W-1:0] div_q;
  logic             clk_q;
  logic             wrap;

  assign wrap = div_q >= (fast ? LIM_FAST : LIM_SLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      clk_q <= 1'b0;
    end else if (!active) begin
      div_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign clk_out = clk_q;
  assign tick    = active && clk_q && wrap;  // next edge makes the falling edge

endmodule

// File: rtl/dsd_bit_shifter.sv
module dsd_bit_shifter
  import dsd_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic [LEN_W-1:0]  push_len,
  output logic              ser_bit
);

  logic [WORD_W-1:0] sh_q, pend_q;
  logic [LEN_W-1:0]  left_q, pend_len_q;
  logic              pend_v_q;
  logic              load;

  assign load = active && ((left_q == '0) || (tick && (left_q == LEN_W'(1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      left_q     <= '0;
      pend_q     <= '0;
      pend_len_q <= '0;
      pend_v_q   <= 1'b0;
    end else begin
      if (!active) begin
        sh_q   <= '0;
        left_q <= '0;
      end else if (load) begin
        if (pend_v_q) begin
          sh_q   <= pend_q;
          left_q <= pend_len_q;
        end else begin
          sh_q   <= {DSD_SILENCE, {(WORD_W - 8){1'b0}}};
          left_q <= LEN_W'(8);
        end
      end else if (tick) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end
      if (push) begin
        pend_q     <= push_word;
        pend_len_q <= push_len;
        pend_v_q   <= 1'b1;
      end else if (!active || (load && pend_v_q)) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign ser_bit = sh_q[WORD_W-1];

endmodule

// File: rtl/dsd_unpack.sv
module dsd_unpack
  import dsd_unpack_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int CLK_HALF    = 2,
  parameter int ACQ_FRAMES  = 4,
  parameter int LOSS_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  input  logic              rate_hi,
  input  logic              direct_sel,
  output logic              dsd_clk,
  output logic              dsd_dl,
  output logic              dsd_dr,
  output logic              dsd_flag,
  output logic              dsd_128
);

  localparam int LEN_W = $clog2(WORD_W + 1);
  localparam int NCH   = 2;

  logic                         acq_evt, loss_evt, bit_tick, push, clk_raw;
  logic [NCH-1:0][WORD_W-1:0]   chan_in, chan_word;
  logic [NCH-1:0]               chan_bit;
  logic [LEN_W-1:0]             push_len;

  function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] src,
                                                   input logic direct);
    if (direct) return src;
    return {src[DOP_BITS-1:0], {(WORD_W - DOP_BITS){1'b0}}};
  endfunction

  assign chan_in[0] = smp_left;
  assign chan_in[1] = smp_right;
  assign push_len   = direct_sel ? LEN_W'(WORD_W) : LEN_W'(DOP_BITS);

  dsd_marker_detect #(
    .ACQ_FRAMES (ACQ_FRAMES),
    .LOSS_FRAMES(LOSS_FRAMES)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (smp_valid),
    .mark_l    (smp_left[MARK_LSB+7:MARK_LSB]),
    .mark_r    (smp_right[MARK_LSB+7:MARK_LSB]),
    .direct_sel(direct_sel),
    .rate_hi   (rate_hi),
    .dsd_on    (dsd_flag),
    .dsd_hi    (dsd_128),
    .acq_evt   (acq_evt),
    .loss_evt  (loss_evt),
    .push      (push)
  );

  dsd_clkgen #(
    .CLK_HALF(CLK_HALF)
  ) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (dsd_flag),
    .fast   (dsd_128),
    .clk_out(clk_raw),
    .tick   (bit_tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign chan_word[ch] = align_word(chan_in[ch], direct_sel);
    dsd_bit_shifter #(
      .WORD_W(WORD_W),
      .LEN_W (LEN_W)
    ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (dsd_flag),
      .tick     (bit_tick),
      .push     (push),
      .push_word(chan_word[ch]),
      .push_len (push_len),
      .ser_bit  (chan_bit[ch])
    );
  end

  assign dsd_clk = clk_raw & dsd_flag;
  assign dsd_dl  = chan_bit[0] & dsd_flag;
  assign dsd_dr  = chan_bit[1] & dsd_flag;

endmodule

// File: rtl/dsd_unpack_chk.sv
module dsd_unpack_chk (
  input logic clk,
  input logic rst_n,
  input logic dsd_clk,
  input logic dsd_dl,
  input logic dsd_dr,
  input logic dsd_flag,
  input logic dsd_128,
  input logic direct_sel,
  input logic acq_evt,
  input logic loss_evt,
  input logic bit_tick
);

  p_entry_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsd_flag) |-> $past(acq_evt || direct_sel));

  p_exit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsd_flag) |-> ($past(loss_evt) || !$past(direct_sel)));

  p_rate_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dsd_128 |-> dsd_flag);

  p_tick_on_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> dsd_clk);

  p_tick_then_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !dsd_clk);

  p_hold_while_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsd_flag && $past(dsd_flag) && dsd_clk) |-> ($stable(dsd_dl) && $stable(dsd_dr)));

  p_quiet_in_pcm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dsd_flag |-> (!dsd_clk && !dsd_dl && !dsd_dr));

  p_direct_base_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_sel && $past(direct_sel)) |-> !dsd_128);

endmodule

bind dsd_unpack dsd_unpack_chk u_chk (.*);

// File: tb/dsd_unpack_tb.sv
module dsd_unpack_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_l = '0;
  logic [31:0] smp_r = '0;
  logic        rate_hi = 1'b0;
  logic        direct_sel = 1'b0;
  logic        dsd_clk, dsd_dl, dsd_dr, dsd_flag, dsd_128;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsd_unpack #(.WORD_W(32), .CLK_HALF(HALF), .ACQ_FRAMES(4), .LOSS_FRAMES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_l), .smp_right(smp_r),
    .rate_hi(rate_hi), .direct_sel(direct_sel), .dsd_clk(dsd_clk), .dsd_dl(dsd_dl),
    .dsd_dr(dsd_dr), .dsd_flag(dsd_flag), .dsd_128(dsd_128)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // marker byte, right marker byte, expected flag after the frame
  localparam logic [16:0] VEC [12] = '{
    {8'h05, 8'h05, 1'b0},  // R2 first fitting frame
    {8'hFA, 8'hFA, 1'b0},
    {8'h05, 8'h05, 1'b0},  // R2 three frames not enough
    {8'h33, 8'h33, 1'b0},  // R3 illegal marker clears run
    {8'h05, 8'hFA, 1'b0},  // R3 channel mismatch clears run
    {8'hFA, 8'hFA, 1'b0},
    {8'hFA, 8'hFA, 1'b0},  // R3 repeat restarts run at 1
    {8'h05, 8'h05, 1'b0},
    {8'hFA, 8'hFA, 1'b0},
    {8'h05, 8'h05, 1'b1},  // R2 fourth fitting frame acquires
    {8'h11, 8'h11, 1'b1},  // R4 one bad frame tolerated
    {8'h22, 8'h22, 1'b0}   // R4 second bad frame leaves
  };

  bit cap_en = 1'b0;
  bit cap_l[$];
  bit cap_r[$];
  bit clk_prev = 1'b0;
  int cyc = 0, last_rise = 0, last_per = 0;

  always @(negedge clk) begin
    cyc++;
    if (dsd_clk && !clk_prev) begin
      if (cap_en) begin
        cap_l.push_back(dsd_dl);
        cap_r.push_back(dsd_dr);
      end
      last_per  = cyc - last_rise;
      last_rise = cyc;
    end
    clk_prev = dsd_clk;
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mark(input int k);
    return (k % 2 == 1) ? 8'hFA : 8'h05;
  endfunction

  function automatic logic [15:0] pay(input int k, input int ch);
    return 16'(32'hB1C4 ^ (k * 32'h2731) ^ (ch * 32'hF00F));
  endfunction

  function automatic logic [31:0] grab(input bit q[$], input int start, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) begin
      w = {w[30:0], ((start + i) < q.size()) ? q[start + i] : 1'b0};
    end
    return w;
  endfunction

  task automatic send_frame(input logic [7:0] ml, input logic [7:0] mr,
                            input logic [15:0] pl, input logic [15:0] pr);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_l = {8'h00, ml, pl};
    smp_r = {8'h00, mr, pr};
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] wl, wr;
    repeat (3) @(negedge clk);
    chk({dsd_clk, dsd_dl, dsd_dr, dsd_flag, dsd_128} == 5'b0, "R1 in reset",
        {27'b0, dsd_clk, dsd_dl, dsd_dr, dsd_flag, dsd_128}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dsd_flag == 1'b0, "R1 flag after reset", dsd_flag, 0);
    chk(dsd_128 == 1'b0, "R1 rate after reset", dsd_128, 0);
    chk({dsd_clk, dsd_dl, dsd_dr} == 3'b0, "R1 lines after reset", {dsd_clk, dsd_dl, dsd_dr}, 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < 12; i++) begin
      send_frame(VEC[i][16:9], VEC[i][8:1], 16'h1234, 16'h4321);
      chk(dsd_flag == VEC[i][0], $sformatf("R2/R3/R4 vector %0d flag", i), dsd_flag, VEC[i][0]);
    end
    chk(dsd_128 == 1'b0, "R5 low rate class", dsd_128, 0);
    repeat (5) @(negedge clk);

    // DSD64 payload stream: R8 R6 R10
    for (int k = 0; k < 4; k++) send_frame(mark(k), mark(k), pay(k, 0), pay(k, 1));
    chk(dsd_flag == 1'b1, "R2 stream acquired", dsd_flag, 1);
    cap_l.delete();
    cap_r.delete();
    cap_en = 1'b1;
    repeat (40) @(negedge clk);
    for (int k = 4; k < 8; k++) begin
      send_frame(mark(k), mark(k), pay(k, 0), pay(k, 1));
      repeat (126) @(negedge clk);
    end
    repeat (300) @(negedge clk);
    chk(last_per == 4 * HALF, "R6 base rate period", last_per, 4 * HALF);
    chk(cap_l.size() >= 96, "R8 bit count", cap_l.size(), 96);
    for (int j = 0; j < 5; j++) begin
      chk(grab(cap_l, j * 16, 16) == {16'h0, pay(j + 3, 0)}, $sformatf("R8 left word %0d", j),
          grab(cap_l, j * 16, 16), {16'h0, pay(j + 3, 0)});
      chk(grab(cap_r, j * 16, 16) == {16'h0, pay(j + 3, 1)}, $sformatf("R8 right word %0d", j),
          grab(cap_r, j * 16, 16), {16'h0, pay(j + 3, 1)});
    end
    chk(grab(cap_l, 80, 16) == 32'h6969, "R10 left silence", grab(cap_l, 80, 16), 32'h6969);
    chk(grab(cap_r, 80, 16) == 32'h6969, "R10 right silence", grab(cap_r, 80, 16), 32'h6969);
    send_frame(8'h00, 8'h00, 16'h0, 16'h0);
    chk(dsd_flag == 1'b1, "R4 single bad frame", dsd_flag, 1);
    send_frame(8'h00, 8'h00, 16'h0, 16'h0);
    chk(dsd_flag == 1'b0, "R4 second bad frame", dsd_flag, 0);
    chk({dsd_clk, dsd_dl, dsd_dr} == 3'b0, "R7 quiet in PCM", {dsd_clk, dsd_dl, dsd_dr}, 0);
    cap_en = 1'b0;

    // DSD128: R5 R6
    rate_hi = 1'b1;
    for (int k = 0; k < 4; k++) send_frame(mark(k), mark(k), pay(k, 0), pay(k, 1));
    chk(dsd_flag == 1'b1, "R5 acquired at high rate", dsd_flag, 1);
    chk(dsd_128 == 1'b1, "R5 rate flag high", dsd_128, 1);
    repeat (40) @(negedge clk);
    chk(last_per == 2 * HALF, "R6 double rate period", last_per, 2 * HALF);
    send_frame(8'h00, 8'h00, 16'h0, 16'h0);
    send_frame(8'h00, 8'h00, 16'h0, 16'h0);
    chk(dsd_128 == 1'b0, "R5 rate flag drops with mode", dsd_128, 0);
    chk(dsd_flag == 1'b0, "R4 left high rate mode", dsd_flag, 0);

    // direct carriage: R9 R10
    wl = 32'h9E37_79B9;
    wr = 32'h1234_5678;
    @(negedge clk);
    direct_sel = 1'b1;
    smp_valid = 1'b1;
    smp_l = wl;
    smp_r = wr;
    cap_l.delete();
    cap_r.delete();
    cap_en = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(dsd_flag == 1'b1, "R9 direct flag", dsd_flag, 1);
    chk(dsd_128 == 1'b0, "R9 direct base rate flag", dsd_128, 0);
    repeat (400) @(negedge clk);
    chk(last_per == 4 * HALF, "R9 direct period", last_per, 4 * HALF);
    chk(grab(cap_l, 0, 32) == wl, "R9 direct left word", grab(cap_l, 0, 32), wl);
    chk(grab(cap_r, 0, 32) == wr, "R9 direct right word", grab(cap_r, 0, 32), wr);
    chk(grab(cap_l, 32, 8) == 32'h69, "R10 direct silence", grab(cap_l, 32, 8), 32'h69);
    direct_sel = 1'b0;
    @(negedge clk);
    chk(dsd_flag == 1'b0, "R9 direct exit", dsd_flag, 0);
    cap_en = 1'b0;

    finished = 1'b1;
    report();
    $finish;
  end

endmodule